// File: doc/BRIEF.md
# Multi-Mode Address Generation Unit

This unit turns a load/store command into the effective memory address for the access. It also produces the new pointer value for the modes that step a pointer register. A command carries a mode code, a base register value, an index register value, a 16-bit immediate, a scale code and an access-size code. For the four arithmetic modes, the address is ready in the cycle after the command is accepted. The modes are displacement, scaled index, post-increment and pre-decrement.

The fifth mode is memory-indirect. In this mode the base register holds the location of a pointer. The unit first issues a read request at the base value. It waits for the returned pointer and then presents the final access at that pointer.

Three interfaces use valid/ready handshakes.

- **Command port:** it is ready only when the unit is idle, so a command held valid waits and is not lost.
- **Access port:** its outputs stay stable until the consumer raises ready.
- **Pointer-read port:** its request is held until it is taken.

The pointer response is a plain valid strobe with no back-pressure. It is accepted only while the unit is waiting for it.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, acc_valid, ptr_req_valid, busy and wb_en are 0, and cmd_ready is 1.
- R2: For mode code 0 (displacement), acc_addr is cmd_base plus cmd_imm sign-extended to the address width, wrapping modulo 2^AW.
- R3: For mode 0 with cmd_imm equal to zero (register indirect), acc_addr equals cmd_base.
- R4: For mode code 1 (scaled), acc_addr is cmd_base plus cmd_index shifted left by cmd_scale. Scale codes 0 to 3 multiply by 1, 2, 4 and 8.
- R5: For mode code 2 (post-increment), acc_addr is cmd_base and wb_value is cmd_base + 2^cmd_size. Size codes 0 to 3 mean 1, 2, 4 and 8 bytes. wb_en is 1.
- R6: For mode code 3 (pre-decrement), acc_addr and wb_value both equal cmd_base - 2^cmd_size, and wb_en is 1.
- R7: wb_en is 1 only while acc_valid is 1 and the mode was 2 or 3. For every other mode it is 0.
- R8: For mode code 4 (memory indirect), the unit first raises ptr_req_valid with ptr_req_addr equal to cmd_base. The response data taken on ptr_rsp_valid becomes acc_addr. acc_size always echoes cmd_size.
- R9: busy is 1 from the cycle after an indirect command is accepted until the final access is presented. cmd_ready is 0 whenever busy or acc_valid is 1. A command offered during that time is not taken and causes no access.
- R10: While acc_valid is 1 and acc_ready is 0, acc_valid, acc_addr, wb_en and wb_value hold. While ptr_req_valid is 1 and ptr_req_ready is 0, the request and its address hold.
- R11: A non-indirect command accepted at a clock edge shows acc_valid at the next edge. An access is consumed at the edge where acc_ready is 1.
- R12: Mode codes 5, 6 and 7 behave as displacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_mode | input | 3 | Addressing mode code |
| cmd_base | input | AW | Base/pointer register value |
| cmd_index | input | AW | Index register value |
| cmd_imm | input | 16 | Signed displacement |
| cmd_scale | input | 2 | Index shift amount |
| cmd_size | input | 2 | log2 of access bytes |
| acc_valid | output | 1 | Final access presented |
| acc_ready | input | 1 | Access consumed |
| acc_addr | output | AW | Effective address |
| acc_size | output | 2 | Echoed size code |
| wb_en | output | 1 | Pointer writeback enable |
| wb_value | output | AW | New pointer value |
| ptr_req_valid | output | 1 | Pointer read request |
| ptr_req_ready | input | 1 | Pointer read accepted |
| ptr_req_addr | output | AW | Pointer location |
| ptr_rsp_valid | input | 1 | Pointer data returned |
| ptr_rsp_data | input | AW | Fetched pointer |
| busy | output | 1 | Indirect fetch in progress |

## Verification
On every cycle, the assertions check the handshake rules and the writeback rules:

- held access and held pointer request under back-pressure;
- cmd_ready low while the unit is occupied;
- pointer requests only while busy, never together with an access;
- writeback enabled only alongside an access, with a value one access step above the address or equal to it.

The arithmetic of each mode, the sign extension of the immediate, the scale and size encodings, and the routing of the fetched pointer to the final address need the bench's sweeps. The same holds for showing that a command offered while busy produces no access.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_DISP     = 3'd0,
    AM_SCALED   = 3'd1,
    AM_POSTINC  = 3'd2,
    AM_PREDEC   = 3'd3,
    AM_INDIRECT = 3'd4
  } am_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE     = 2'd0,
    SQ_PTR_REQ  = 2'd1,
    SQ_PTR_WAIT = 2'd2,
    SQ_ISSUE    = 2'd3
  } sq_state_e;

endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [IW-1:0] imm,
  input  logic [1:0]    scale,
  input  logic [1:0]    size,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] wb_value,
  output logic          wb_en,
  output logic          indirect
);

  localparam int EXT = AW - IW;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] scaled_off;
  logic [AW-1:0] step;

  // Sign-extend the displacement, or truncate it when the address is narrower.
  generate
    if (EXT > 0) begin : g_sext
      assign disp_ext = {{EXT{imm[IW-1]}}, imm};
    end else begin : g_trunc
      assign disp_ext = imm[AW-1:0];
    end
  endgenerate

  assign scaled_off = index << scale;
  assign step       = {{(AW-1){1'b0}}, 1'b1} << size;

  always_comb begin
    eff_addr = base + disp_ext;
    wb_value = '0;
    wb_en    = 1'b0;
    indirect = 1'b0;
    case (am_mode_e'(mode))
      AM_SCALED: eff_addr = base + scaled_off;
      AM_POSTINC: begin
        eff_addr = base;
        wb_value = base + step;
        wb_en    = 1'b1;
      end
      AM_PREDEC: begin
        eff_addr = base - step;
        wb_value = base - step;
        wb_en    = 1'b1;
      end
      AM_INDIRECT: begin
        eff_addr = base;
        indirect = 1'b1;
      end
      default: eff_addr = base + disp_ext;
    endcase
  end

endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_size,
  input  logic [AW-1:0] calc_addr,
  input  logic [AW-1:0] calc_wb,
  input  logic          calc_wb_en,
  input  logic          calc_indirect,
  output logic          acc_valid,
  input  logic          acc_ready,
  output logic [AW-1:0] acc_addr,
  output logic [1:0]    acc_size,
  output logic          wb_en,
  output logic [AW-1:0] wb_value,
  output logic          ptr_req_valid,
  input  logic          ptr_req_ready,
  output logic [AW-1:0] ptr_req_addr,
  input  logic          ptr_rsp_valid,
  input  logic [AW-1:0] ptr_rsp_data,
  output logic          busy
);

  sq_state_e     state;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] wb_q;
  logic          wb_en_q;
  logic [1:0]    size_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      addr_q  <= '0;
      wb_q    <= '0;
      wb_en_q <= 1'b0;
      size_q  <= '0;
      ptr_q   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            size_q <= cmd_size;
            if (calc_indirect) begin
              ptr_q   <= calc_addr;
              wb_q    <= '0;
              wb_en_q <= 1'b0;
              state   <= SQ_PTR_REQ;
            end else begin
              addr_q  <= calc_addr;
              wb_q    <= calc_wb;
              wb_en_q <= calc_wb_en;
              state   <= SQ_ISSUE;
            end
          end
        end
        SQ_PTR_REQ: begin
          if (ptr_req_ready) state <= SQ_PTR_WAIT;
        end
        SQ_PTR_WAIT: begin
          if (ptr_rsp_valid) begin
            addr_q <= ptr_rsp_data;
            state  <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          if (acc_ready) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == SQ_IDLE);
  assign acc_valid     = (state == SQ_ISSUE);
  assign acc_addr      = addr_q;
  assign acc_size      = size_q;
  assign wb_en         = acc_valid & wb_en_q;
  assign wb_value      = wb_q;
  assign ptr_req_valid = (state == SQ_PTR_REQ);
  assign ptr_req_addr  = ptr_q;
  assign busy          = (state == SQ_PTR_REQ) || (state == SQ_PTR_WAIT);

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_mode,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_index,
  input  logic [15:0]   cmd_imm,
  input  logic [1:0]    cmd_scale,
  input  logic [1:0]    cmd_size,
  output logic          acc_valid,
  input  logic          acc_ready,
  output logic [AW-1:0] acc_addr,
  output logic [1:0]    acc_size,
  output logic          wb_en,
  output logic [AW-1:0] wb_value,
  output logic          ptr_req_valid,
  input  logic          ptr_req_ready,
  output logic [AW-1:0] ptr_req_addr,
  input  logic          ptr_rsp_valid,
  input  logic [AW-1:0] ptr_rsp_data,
  output logic          busy
);

  localparam int IMM_W = 16;

  logic [AW-1:0] calc_addr;
  logic [AW-1:0] calc_wb;
  logic          calc_wb_en;
  logic          calc_indirect;

  agu_addr_calc #(.AW(AW), .IW(IMM_W)) u_calc (
    .mode     (cmd_mode),
    .base     (cmd_base),
    .index    (cmd_index),
    .imm      (cmd_imm),
    .scale    (cmd_scale),
    .size     (cmd_size),
    .eff_addr (calc_addr),
    .wb_value (calc_wb),
    .wb_en    (calc_wb_en),
    .indirect (calc_indirect)
  );

  agu_seq #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_size      (cmd_size),
    .calc_addr     (calc_addr),
    .calc_wb       (calc_wb),
    .calc_wb_en    (calc_wb_en),
    .calc_indirect (calc_indirect),
    .acc_valid     (acc_valid),
    .acc_ready     (acc_ready),
    .acc_addr      (acc_addr),
    .acc_size      (acc_size),
    .wb_en         (wb_en),
    .wb_value      (wb_value),
    .ptr_req_valid (ptr_req_valid),
    .ptr_req_ready (ptr_req_ready),
    .ptr_req_addr  (ptr_req_addr),
    .ptr_rsp_valid (ptr_rsp_valid),
    .ptr_rsp_data  (ptr_rsp_data),
    .busy          (busy)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_size,
  input logic          wb_en,
  input logic [AW-1:0] wb_value,
  input logic          ptr_req_valid,
  input logic          ptr_req_ready,
  input logic [AW-1:0] ptr_req_addr,
  input logic          busy
);

  logic [AW-1:0] chk_step;
  assign chk_step = {{(AW-1){1'b0}}, 1'b1} << acc_size;

  a_r9_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || acc_valid) |-> !cmd_ready);

  a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=>
      (acc_valid && $stable(acc_addr) && $stable(wb_en) && $stable(wb_value)));

  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_req_valid && !ptr_req_ready) |=> (ptr_req_valid && $stable(ptr_req_addr)));

  a_r7_wb_only_with_access: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> acc_valid);

  a_r5_wb_step_relation: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ((wb_value == acc_addr + chk_step) || (wb_value == acc_addr)));

  a_r8_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req_valid |-> (busy && !acc_valid));

endmodule

bind addr_gen_unit agu_checker #(.AW(AW)) u_agu_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .acc_valid     (acc_valid),
  .acc_ready     (acc_ready),
  .acc_addr      (acc_addr),
  .acc_size      (acc_size),
  .wb_en         (wb_en),
  .wb_value      (wb_value),
  .ptr_req_valid (ptr_req_valid),
  .ptr_req_ready (ptr_req_ready),
  .ptr_req_addr  (ptr_req_addr),
  .busy          (busy)
);

// File: tb/test_addr_gen_unit.sv
`timescale 1ns/1ps
module test_addr_gen_unit;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [2:0]    cmd_mode;
  logic [AW-1:0] cmd_base;
  logic [AW-1:0] cmd_index;
  logic [15:0]   cmd_imm;
  logic [1:0]    cmd_scale;
  logic [1:0]    cmd_size;
  logic          acc_valid;
  logic          acc_ready;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic          wb_en;
  logic [AW-1:0] wb_value;
  logic          ptr_req_valid;
  logic          ptr_req_ready;
  logic [AW-1:0] ptr_req_addr;
  logic          ptr_rsp_valid;
  logic [AW-1:0] ptr_rsp_data;
  logic          busy;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  addr_gen_unit #(.AW(AW)) i_addr_gen_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Non-indirect command: accepted at the next edge, access visible one edge later.
  task automatic run_simple(input string tag, input logic [2:0] m, input logic [AW-1:0] b,
                            input logic [AW-1:0] x, input logic [15:0] im,
                            input logic [1:0] sc, input logic [1:0] sz,
                            input logic [AW-1:0] exp_addr, input logic exp_wben,
                            input logic [AW-1:0] exp_wb);
    @(negedge clk);
    check({tag, " R9 idle cmd_ready"}, 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_mode = m; cmd_base = b; cmd_index = x;
    cmd_imm = im; cmd_scale = sc; cmd_size = sz;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({tag, " R11 acc_valid"}, 32'(acc_valid), 32'd1);
    check({tag, " addr"}, 32'(acc_addr), 32'(exp_addr));
    check({tag, " R7 wb_en"}, 32'(wb_en), 32'(exp_wben));
    if (exp_wben) check({tag, " wb_value"}, 32'(wb_value), 32'(exp_wb));
    check({tag, " acc_size"}, 32'(acc_size), 32'(sz));
    @(negedge clk);
    check({tag, " R11 consumed"}, 32'(acc_valid), 32'd0);
  endtask

  // Memory-indirect flow, optionally with a stalled request and a command held during busy.
  task automatic run_ind(input logic [AW-1:0] b, input logic [AW-1:0] ptr,
                         input logic [1:0] sz, input logic stall, input logic hold_cmd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 3'd4; cmd_base = b; cmd_size = sz;
    cmd_imm = 16'h0040; cmd_index = '0; cmd_scale = 2'd0;
    ptr_req_ready = !stall;
    @(negedge clk);
    if (hold_cmd) begin
      cmd_mode = 3'd0; cmd_base = b ^ 24'h00F0F0; cmd_size = 2'd3;
    end else cmd_valid = 1'b0;
    check("R8 ptr_req_valid", 32'(ptr_req_valid), 32'd1);
    check("R8 ptr_req_addr", 32'(ptr_req_addr), 32'(b));
    check("R9 busy during request", 32'(busy), 32'd1);
    check("R9 cmd_ready low", 32'(cmd_ready), 32'd0);
    if (stall) begin
      @(negedge clk);
      check("R10 ptr req held", 32'(ptr_req_valid), 32'd1);
      check("R10 ptr addr held", 32'(ptr_req_addr), 32'(b));
      ptr_req_ready = 1'b1;
    end
    @(negedge clk);
    check("R8 request taken", 32'(ptr_req_valid), 32'd0);
    check("R9 busy waiting", 32'(busy), 32'd1);
    check("R9 no access while waiting", 32'(acc_valid), 32'd0);
    ptr_rsp_valid = 1'b1; ptr_rsp_data = ptr;
    @(negedge clk);
    ptr_rsp_valid = 1'b0;
    cmd_valid = 1'b0;
    check("R8 final acc_valid", 32'(acc_valid), 32'd1);
    check("R8 final addr", 32'(acc_addr), 32'(ptr));
    check("R8 acc_size", 32'(acc_size), 32'(sz));
    check("R9 busy cleared", 32'(busy), 32'd0);
    check("R7 no wb in indirect", 32'(wb_en), 32'd0);
    @(negedge clk);
    check("R9 held command ignored acc", 32'(acc_valid), 32'd0);
    check("R9 held command ignored req", 32'(ptr_req_valid), 32'd0);
    check("R9 held command ignored busy", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [AW-1:0] bases [4];
    logic [15:0]   imms [6];
    logic [AW-1:0] idxs [4];
    bases = '{24'h000000, 24'h001000, 24'h7FFFF8, 24'hFFFFFC};
    imms  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFC0};
    idxs  = '{24'h000000, 24'h000001, 24'h000123, 24'hFFFFFF};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = '0; cmd_base = '0; cmd_index = '0;
    cmd_imm = '0; cmd_scale = '0; cmd_size = '0; acc_ready = 1'b1;
    ptr_req_ready = 1'b1; ptr_rsp_valid = 1'b0; ptr_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 acc_valid", 32'(acc_valid), 32'd0);
    check("R1 ptr_req_valid", 32'(ptr_req_valid), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 wb_en", 32'(wb_en), 32'd0);
    check("R1 cmd_ready", 32'(cmd_ready), 32'd1);

    // R2 displacement sweep, sign extension of the immediate
    foreach (bases[i]) foreach (imms[j])
      run_simple("R2 disp", 3'd0, bases[i], 24'h00ABCD, imms[j], 2'd2, 2'd1,
                 bases[i] + {{8{imms[j][15]}}, imms[j]}, 1'b0, '0);
    // R3 register indirect
    foreach (bases[i])
      run_simple("R3 zero offset", 3'd0, bases[i], 24'h000777, 16'h0000, 2'd3, 2'd2,
                 bases[i], 1'b0, '0);
    // R4 scaled sweep
    foreach (bases[i]) foreach (idxs[j])
      for (int s = 0; s < 4; s++)
        run_simple("R4 scaled", 3'd1, bases[i], idxs[j], 16'h1234, 2'(s), 2'd0,
                   bases[i] + (idxs[j] << s), 1'b0, '0);
    // R5 / R6 pointer modes over every size
    foreach (bases[i])
      for (int z = 0; z < 4; z++) begin
        run_simple("R5 postinc", 3'd2, bases[i], 24'h000055, 16'h0010, 2'd1, 2'(z),
                   bases[i], 1'b1, bases[i] + (24'd1 << z));
        run_simple("R6 predec", 3'd3, bases[i], 24'h000055, 16'h0010, 2'd1, 2'(z),
                   bases[i] - (24'd1 << z), 1'b1, bases[i] - (24'd1 << z));
      end
    // R12 unassigned codes fall back to displacement
    for (int m = 5; m < 8; m++)
      run_simple("R12 spare code", 3'(m), 24'h010000, 24'h000009, 16'hFFF0, 2'd3, 2'd3,
                 24'h00FFF0, 1'b0, '0);

    // R8 / R9 indirect sequences
    run_ind(24'h002000, 24'hABC123, 2'd2, 1'b0, 1'b0);
    run_ind(24'hFFFFF0, 24'h000008, 2'd3, 1'b1, 1'b0);
    run_ind(24'h000100, 24'h5A5A5A, 2'd0, 1'b0, 1'b1);
    run_ind(24'h123456, 24'h000000, 2'd1, 1'b1, 1'b1);

    // R10 access back-pressure
    acc_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 3'd2; cmd_base = 24'h000400; cmd_size = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10 acc held", 32'(acc_valid), 32'd1);
      check("R10 addr held", 32'(acc_addr), 32'h000400);
      check("R10 wb held", 32'(wb_value), 32'h000404);
      check("R10 wb_en held", 32'(wb_en), 32'd1);
      check("R9 cmd_ready low while presenting", 32'(cmd_ready), 32'd0);
      @(negedge clk);
    end
    acc_ready = 1'b1;
    @(negedge clk);
    check("R10 released", 32'(acc_valid), 32'd0);
    check("R7 wb_en after release", 32'(wb_en), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule